// File: doc/BRIEF.md
# CCK Eight-Chip Symbol Encoder

This block turns data symbols into complementary-code-keyed chip sequences for a direct-sequence transmitter. Each accepted symbol yields eight chips. Each chip is given as a 2-bit quadrant phase index, a count of pi/2 steps, and one chip advances per chip-enable pulse. There are two rates. In the high rate, eight data bits select all four phase terms. In the low rate, four bits select the first phase term and one of a small set of basic codes.

The first phase term is differentially encoded. A symbol's rotation is added to the first phase term of the symbol before it. Every second symbol of a frame gets an extra half-turn. A frame-start pulse clears that history and drops any symbol still being sent. Symbols can follow one another with no idle cycle, because a new symbol is accepted during the last chip of the current one. The block ends at phase indices. I/Q mapping, filtering and scrambling sit downstream.

Top module: `cck_symbol_encoder`

## Requirements
- R1: After reset, `chip_valid` and `chip_last` are 0, `sym_ready` is 1, and the differential reference and symbol parity are 0.
- R2: In high rate (`rate_hi`=1), each bit pair {d(2i+1),d(2i)} maps to a phase count equal to its binary value (0, 1, 2, 3 meaning 0, pi/2, pi, 3pi/2). The terms are taken as follows: phi2 = data[3:2], phi3 = data[5:4], phi4 = data[7:6].
- R3: Chip k (k=0 first, k=7 last) has phase phi1 + (k even ? phi2) + (bit1 of k clear ? phi3) + (bit2 of k clear ? phi4), plus 2 when k is 3 or 6 (cover code). The sum is taken modulo 4.
- R4: In low rate (`rate_hi`=0), phi2 = 2*data[2]+1, phi3 = 0, phi4 = 2*data[3]. Bits data[7:4] have no effect on any chip.
- R5: phi1 = previous symbol's phi1 + data[1:0] + (2 if the symbol is the second, fourth, ... of the frame), modulo 4. This holds in both rates, and the first symbol after reset or frame start uses a reference of 0.
- R6: A `frame_start` pulse clears the reference and the parity, and ends any symbol in progress. `chip_valid` is 0 in the next cycle.
- R7: While `chip_valid` is 1, a chip advances only on a cycle with `chip_en`=1. Otherwise `chip_phase` holds. `chip_last` is 1 exactly on the eighth chip.
- R8: A symbol accepted during the eighth chip with `chip_en`=1 starts at chip 0 in the next cycle, with no gap.
- R9: `sym_ready` is 1 only when no symbol is pending or when the eighth chip is being consumed, and never while `frame_start` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chip_en | input | 1 | Chip-rate enable; consumes the present chip |
| frame_start | input | 1 | Clears differential history and aborts the current symbol |
| rate_hi | input | 1 | 1: eight bits per symbol, 0: four bits per symbol |
| sym_valid | input | 1 | A data symbol is offered |
| sym_data | input | 8 | Symbol bits, d0 in bit 0 |
| sym_ready | output | 1 | The offered symbol is taken this cycle |
| chip_valid | output | 1 | `chip_phase` carries a chip |
| chip_phase | output | 2 | Chip phase in pi/2 steps |
| chip_last | output | 1 | Present chip is the eighth of its symbol |

## Verification
The hardest case to reach is a new symbol handed over during the last chip of the previous one. That handover must carry the chained reference and the flipped parity into a symbol that starts at once. The stimulus raises `sym_valid` together with `chip_en` on the eighth chip and checks the following chip 0 against a model that updates the reference at the same instant. A second hard case is a frame start arriving mid-symbol. The stimulus aborts a symbol after three chips, then checks that the next symbol is encoded against a zero reference with even parity.

// File: rtl/cck_enc_pkg.sv
package cck_enc_pkg;
    localparam int CHIPS   = 8;
    localparam int IDX_W   = $clog2(CHIPS);
    localparam int DATA_W  = 8;
    localparam int PH_W    = 2;

    typedef logic [PH_W-1:0] quad_t;

    typedef struct packed {
        logic             busy;
        logic [IDX_W-1:0] idx;
        quad_t            ref_ph;
        logic             odd;
        quad_t            p1;
        quad_t            p2;
        quad_t            p3;
        quad_t            p4;
    } enc_state_t;
endpackage

// File: rtl/cck_phase_map.sv
module cck_phase_map
    import cck_enc_pkg::*;
(
    input  logic              rate_hi,
    input  logic [DATA_W-1:0] data,
    input  quad_t             ref_ph,
    input  logic              odd,
    output quad_t             p1,
    output quad_t             p2,
    output quad_t             p3,
    output quad_t             p4
);
    quad_t delta;
    quad_t odd_rot;

    always_comb begin
        delta   = data[1:0];
        odd_rot = odd ? quad_t'(2) : quad_t'(0);
        p1      = ref_ph + delta + odd_rot;
        if (rate_hi) begin
            p2 = data[3:2];
            p3 = data[5:4];
            p4 = data[7:6];
        end else begin
            p2 = {data[2], 1'b1};
            p3 = '0;
            p4 = {data[3], 1'b0};
        end
    end
endmodule

// File: rtl/cck_chip_sum.sv
module cck_chip_sum
    import cck_enc_pkg::*;
#(
    parameter logic [CHIPS-1:0] COVER_MASK = 8'b0100_1000
) (
    input  quad_t            p1,
    input  quad_t            p2,
    input  quad_t            p3,
    input  quad_t            p4,
    input  logic [IDX_W-1:0] idx,
    output quad_t            phase
);
    quad_t chip_ph [CHIPS];

    for (genvar k = 0; k < CHIPS; k++) begin : g_chip
        localparam bit USE2 = (k % 2) == 0;
        localparam bit USE3 = ((k / 2) % 2) == 0;
        localparam bit USE4 = ((k / 4) % 2) == 0;
        assign chip_ph[k] = p1
                          + (USE2 ? p2 : quad_t'(0))
                          + (USE3 ? p3 : quad_t'(0))
                          + (USE4 ? p4 : quad_t'(0))
                          + (COVER_MASK[k] ? quad_t'(2) : quad_t'(0));
    end

    assign phase = chip_ph[idx];
endmodule

// File: rtl/cck_symbol_encoder.sv
module cck_symbol_encoder
    import cck_enc_pkg::*;
#(
    parameter logic [CHIPS-1:0] COVER_MASK = 8'b0100_1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_en,
    input  logic              frame_start,
    input  logic              rate_hi,
    input  logic              sym_valid,
    input  logic [DATA_W-1:0] sym_data,
    output logic              sym_ready,
    output logic              chip_valid,
    output logic [PH_W-1:0]   chip_phase,
    output logic              chip_last
);
    enc_state_t st_d, st_q;
    quad_t      m_p1, m_p2, m_p3, m_p4;
    logic       last_q;
    logic       accept;

    cck_phase_map u_map (
        .rate_hi (rate_hi),
        .data    (sym_data),
        .ref_ph  (st_q.ref_ph),
        .odd     (st_q.odd),
        .p1      (m_p1),
        .p2      (m_p2),
        .p3      (m_p3),
        .p4      (m_p4)
    );

    cck_chip_sum #(.COVER_MASK(COVER_MASK)) u_sum (
        .p1    (st_q.p1),
        .p2    (st_q.p2),
        .p3    (st_q.p3),
        .p4    (st_q.p4),
        .idx   (st_q.idx),
        .phase (chip_phase)
    );

    assign last_q     = st_q.busy && (st_q.idx == IDX_W'(CHIPS - 1));
    assign sym_ready  = !frame_start && (!st_q.busy || (chip_en && last_q));
    assign accept     = sym_valid && sym_ready;
    assign chip_valid = st_q.busy;
    assign chip_last  = last_q;

    always_comb begin
        st_d = st_q;
        if (frame_start) begin
            st_d.busy   = 1'b0;
            st_d.idx    = '0;
            st_d.ref_ph = '0;
            st_d.odd    = 1'b0;
        end else begin
            if (st_q.busy && chip_en) begin
                st_d.idx = st_q.idx + IDX_W'(1);
                if (last_q) begin
                    st_d.busy = 1'b0;
                end
            end
            if (accept) begin
                st_d.busy   = 1'b1;
                st_d.idx    = '0;
                st_d.p1     = m_p1;
                st_d.p2     = m_p2;
                st_d.p3     = m_p3;
                st_d.p4     = m_p4;
                st_d.ref_ph = m_p1;
                st_d.odd    = !st_q.odd;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R7
    chip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_valid && !chip_en && !frame_start)
            |=> (chip_valid && $stable(chip_phase) && $stable(chip_last)));

    // R6
    frame_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> !chip_valid);

    // R9
    ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_valid && !(chip_en && chip_last)) |-> !sym_ready);

    // R8
    chain_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_valid && chip_last && chip_en && sym_valid && sym_ready)
            |=> (chip_valid && !chip_last));

    // R5
    last_ref_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_valid && chip_last) |-> (chip_phase == st_q.ref_ph));
endmodule

// File: tb/cck_symbol_encoder_test.sv
module cck_symbol_encoder_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       chip_en = 1'b0;
    logic       frame_start = 1'b0;
    logic       rate_hi = 1'b0;
    logic       sym_valid = 1'b0;
    logic [7:0] sym_data = '0;
    logic       sym_ready;
    logic       chip_valid;
    logic [1:0] chip_phase;
    logic       chip_last;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [1:0] m_ref = 2'd0;
    logic       m_odd = 1'b0;
    logic [1:0] exp_ch [8];

    always #10 clk = ~clk;

    cck_symbol_encoder uut (
        .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .frame_start(frame_start),
        .rate_hi(rate_hi), .sym_valid(sym_valid), .sym_data(sym_data),
        .sym_ready(sym_ready), .chip_valid(chip_valid),
        .chip_phase(chip_phase), .chip_last(chip_last)
    );

    // {rate_hi, data}
    localparam logic [8:0] VEC [0:9] = '{
        9'h1_00, 9'h1_E4, 9'h1_1B, 9'h1_FF, 9'h0_05,
        9'h0_FA, 9'h0_0C, 9'h1_93, 9'h0_A3, 9'h1_6D
    };

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Model from R2, R3, R4, R5
    task automatic model(input logic hi, input logic [7:0] d);
        logic [1:0] p1, p2, p3, p4, s;
        p1 = m_ref + d[1:0] + (m_odd ? 2'd2 : 2'd0);
        if (hi) begin
            p2 = d[3:2]; p3 = d[5:4]; p4 = d[7:6];
        end else begin
            p2 = d[2] ? 2'd3 : 2'd1; p3 = 2'd0; p4 = d[3] ? 2'd2 : 2'd0;
        end
        for (int k = 0; k < 8; k++) begin
            s = p1;
            if (k % 2 == 0) s = s + p2;
            if ((k / 2) % 2 == 0) s = s + p3;
            if ((k / 4) % 2 == 0) s = s + p4;
            if (k == 3 || k == 6) s = s + 2'd2;
            exp_ch[k] = s;
        end
        m_ref = p1;
        m_odd = ~m_odd;
    endtask

    // starts and ends at a negedge
    task automatic load(input logic hi, input logic [7:0] d);
        sym_valid = 1'b1; rate_hi = hi; sym_data = d; chip_en = 1'b0;
        #1;
        check(sym_ready === 1'b1, "R9 ready when idle", int'(sym_ready), 1);
        model(hi, d);
        @(posedge clk); @(negedge clk);
        sym_valid = 1'b0;
    endtask

    task automatic play(input int n, input bit chain, input logic hi, input logic [7:0] d);
        for (int k = 0; k < n; k++) begin
            chip_en = 1'b1;
            if (chain && k == 7) begin
                sym_valid = 1'b1; rate_hi = hi; sym_data = d;
            end
            #1;
            check(chip_valid === 1'b1 && chip_phase === exp_ch[k],
                  $sformatf("R3 chip %0d phase", k), int'(chip_phase), int'(exp_ch[k]));
            check(chip_last === (k == 7), "R7 last flag", int'(chip_last), int'(k == 7));
            if (k == 3) check(sym_ready === 1'b0, "R9 busy not ready", int'(sym_ready), 0);
            if (chain && k == 7) begin
                check(sym_ready === 1'b1, "R8 ready on last chip", int'(sym_ready), 1);
                model(hi, d);
            end
            @(posedge clk); @(negedge clk);
            sym_valid = 1'b0;
            chip_en = 1'b0;
        end
    endtask

    task automatic frame_pulse();
        frame_start = 1'b1;
        sym_valid = 1'b1;
        #1;
        check(sym_ready === 1'b0, "R9 not ready on frame start", int'(sym_ready), 0);
        @(posedge clk); @(negedge clk);
        frame_start = 1'b0;
        sym_valid = 1'b0;
        m_ref = 2'd0; m_odd = 1'b0;
        #1;
        check(chip_valid === 1'b0, "R6 aborted symbol", int'(chip_valid), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [1:0] lo_ref [8];
        repeat (3) @(negedge clk);
        #1;
        // R1 reset state
        check(chip_valid === 1'b0, "R1 valid after reset", int'(chip_valid), 0);
        check(chip_last === 1'b0, "R1 last after reset", int'(chip_last), 0);
        check(sym_ready === 1'b1, "R1 ready after reset", int'(sym_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector walk, R2 R4 R5 via chained parity and reference
        for (int i = 0; i < 10; i++) begin
            load(VEC[i][8], VEC[i][7:0]);
            play(8, 1'b0, 1'b0, 8'h00);
        end

        // R4: upper bits ignored in low rate
        frame_pulse();
        load(1'b0, 8'h06);
        for (int k = 0; k < 8; k++) lo_ref[k] = exp_ch[k];
        play(8, 1'b0, 1'b0, 8'h00);
        frame_pulse();
        load(1'b0, 8'hF6);
        for (int k = 0; k < 8; k++)
            check(exp_ch[k] == lo_ref[k], "R4 model upper bits", int'(exp_ch[k]), int'(lo_ref[k]));
        play(8, 1'b0, 1'b0, 8'h00);

        // R7 hold without chip_en
        load(1'b1, 8'h5A);
        for (int j = 0; j < 3; j++) begin
            #1;
            check(chip_valid === 1'b1 && chip_phase === exp_ch[0],
                  "R7 hold without enable", int'(chip_phase), int'(exp_ch[0]));
            @(posedge clk); @(negedge clk);
        end
        play(8, 1'b0, 1'b0, 8'h00);

        // R8 back-to-back chain of three symbols
        load(1'b1, 8'h37);
        play(8, 1'b1, 1'b0, 8'h09);
        play(8, 1'b1, 1'b1, 8'hC2);
        play(8, 1'b0, 1'b0, 8'h00);

        // R6 frame start mid-symbol, then R5 zero reference
        load(1'b1, 8'h81);
        play(3, 1'b0, 1'b0, 8'h00);
        frame_pulse();
        load(1'b1, 8'h4E);
        play(8, 1'b0, 1'b0, 8'h00);
        load(1'b0, 8'h03);
        play(8, 1'b0, 1'b0, 8'h00);

        #1;
        check(chip_valid === 1'b0, "R7 idle after last chip", int'(chip_valid), 0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule